// File: doc/BRIEF.md
# Dual-Slope Frequency-Correct PWM Timer

This block is a 16-bit timer whose counter runs up from zero to a programmable ceiling and then back down to zero, over and over. Two compare channels watch the counter and each drives a PWM pin. A channel's level changes where the counter meets its compare value on the rising slope and again on the falling slope, so each pulse sits centred in the period. The ceiling and the compare values are written into holding registers. They become active only when the counter is at zero, so every period is symmetric and its length is exact, even while software reprograms it.

A prescaler does not make a second clock. It makes a single-cycle count enable once every 1, 8, 64, 256 or 1024 clock cycles. A small write-only register port loads the ceiling, the compare values and a control word. The control word holds the prescale select and a two-bit output mode for each channel. Events at the compare points, at the ceiling and at zero set sticky flags. Writing a one to a flag bit clears that flag.

Top module: `pfc_pwm_timer`

## Requirements
- R1: Control bits [2:0] choose the count enable. Codes 1, 2, 3, 4 and 5 give one enable every 1, 8, 64, 256 and 1024 clock cycles. Codes 0, 6 and 7 stop the counter, which then holds its value.
- R2: With an active ceiling T ≥ 1, the counter steps by one on each enable, 0, 1, …, T, T−1, …, 1, 0. One period takes 2·T·N clock cycles, where N is the prescale factor, and the counter never exceeds T.
- R3: Output mode 2 (non-inverted) drives the pin low after an enabled cycle in which the counter equals the compare value C while rising. It drives the pin high after such a cycle while falling. For 0 < C < T, the pin is high for 2·C·N clock cycles of every period.
- R4: Output mode 3 gives the complement of mode 2, so the pin is high for 2·(T−C)·N clock cycles of every period.
- R5: In output modes 0 and 1 the pin is held low.
- R6: In mode 2, C = 0 keeps the pin low all the time and C = T keeps it high all the time. In mode 3 both levels are reversed.
- R7: A compare write goes to a holding register. It is applied only on the enabled cycle in which the counter is zero, so a write in mid-period leaves the rest of that period unchanged.
- R8: A ceiling write goes to a holding register and is applied on the enabled cycle in which the counter is zero. The period in progress still turns at the old ceiling.
- R9: Flag bit k (k = 0, 1) is low in a cycle where the counter equals channel k's compare value on an enabled cycle, and it reads high in the next cycle.
- R10: Flag bit 2 is set after an enabled cycle at zero, and flag bit 3 after an enabled cycle at the ceiling. No flag becomes set without a count enable.
- R11: Writing to the flag address clears every flag whose data bit is 1 and leaves flags written with 0 unchanged. When a set and a clear fall on the same cycle, the set wins.
- R12: The address map is ceiling 0, compare 0 at 1, compare 1 at 2, control 3 and flags 4. In the control word, mode 0 sits at bits [4:3] and mode 1 at bits [6:5]. After reset all registers are zero, the counter reads 0, and the pins and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pwm_o | output | 2 | PWM pins, one per channel |
| flags_o | output | 4 | Sticky flags: matches [1:0], zero [2], ceiling [3] |
| cnt_o | output | 16 | Current counter value |

## Verification
A counter that turned at the wrong point, or a ceiling applied mid-period, shows at once on the counter port and within one period as a wrong period length. A compare value that took effect before zero, or a wrong turnaround rule, changes the pin level at the next crossing. So high-time counts over one period, and level samples just past a crossing, expose it within that period. Flag faults show one cycle after the enabled cycle that should set them, or in the cycle right after a clearing write.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

    localparam int unsigned DIV_W = 10;

    typedef enum logic [1:0] {
        OMODE_OFF_A  = 2'd0,
        OMODE_OFF_B  = 2'd1,
        OMODE_DIRECT = 2'd2,
        OMODE_INVERT = 2'd3
    } omode_e;

    typedef struct packed {
        logic at_bottom;
        logic at_top;
        logic up;
    } cnt_evt_t;

    function automatic logic sel_running(input logic [2:0] sel);
        return (sel >= 3'd1) && (sel <= 3'd5);
    endfunction

    function automatic logic [DIV_W-1:0] div_mask(input logic [2:0] sel);
        case (sel)
            3'd2:    return DIV_W'(7);
            3'd3:    return DIV_W'(63);
            3'd4:    return DIV_W'(255);
            3'd5:    return DIV_W'(1023);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pfc_pwm_prescaler.sv
module pfc_pwm_prescaler
    import pfc_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + DIV_W'(1);
    end

    assign mask = div_mask(sel);
    assign tick = sel_running(sel) && ((div_q & mask) == mask);
endmodule

// File: rtl/pfc_pwm_updown.sv
module pfc_pwm_updown
    import pfc_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_buf,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] top_act,
    output logic [CNT_W-1:0] top_eff,
    output cnt_evt_t         evt
);
    logic up_q;
    logic at_zero;
    logic turn;

    assign at_zero = (cnt == '0);
    assign top_eff = at_zero ? top_buf : top_act;
    assign turn    = !at_zero && up_q && (cnt >= top_act);

    assign evt.at_bottom = tick && at_zero;
    assign evt.at_top    = tick && turn;
    assign evt.up        = up_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            up_q    <= 1'b1;
            top_act <= '0;
        end else if (tick) begin
            if (at_zero) begin
                top_act <= top_buf;
                up_q    <= 1'b1;
                cnt     <= (top_buf == '0) ? '0 : CNT_W'(1);
            end else if (turn) begin
                up_q <= 1'b0;
                cnt  <= cnt - CNT_W'(1);
            end else if (up_q) begin
                cnt <= cnt + CNT_W'(1);
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pfc_pwm_channel.sv
module pfc_pwm_channel
    import pfc_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] top_eff,
    input  logic             up,
    input  logic [CNT_W-1:0] cmp_buf,
    input  omode_e           mode,
    output logic             hit,
    output logic             pwm
);
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cmp_eff;
    logic             at_zero;
    logic             level_q;

    assign at_zero = (cnt == '0);
    // at zero the value about to become active is the one compared
    assign cmp_eff = at_zero ? cmp_buf : cmp_act;
    assign hit     = tick && (cnt == cmp_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act <= '0;
            level_q <= 1'b0;
        end else begin
            if (tick && at_zero) cmp_act <= cmp_buf;
            if (hit) begin
                if (cnt == top_eff)       level_q <= 1'b1;
                else if (at_zero || up)   level_q <= 1'b0;
                else                      level_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (mode)
            OMODE_DIRECT: pwm = level_q;
            OMODE_INVERT: pwm = ~level_q;
            default:      pwm = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer
    import pfc_pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NCH    = 2,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_o,
    output logic [NCH+1:0]    flags_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam int unsigned NF = NCH + 2;
    localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NCH + 1);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NCH + 2);

    logic [CNT_W-1:0] top_buf_q;
    logic [CNT_W-1:0] cmp_buf_q [NCH];
    logic [2:0]       sel_q;
    omode_e           mode_q    [NCH];
    logic [NF-1:0]    flags_q;

    logic             tick;
    logic [CNT_W-1:0] top_act;
    logic [CNT_W-1:0] top_eff;
    cnt_evt_t         evt;
    logic [NCH-1:0]   hits;
    logic [NF-1:0]    set_vec;
    logic [NF-1:0]    clr_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_buf_q <= '0;
            sel_q     <= '0;
            for (int k = 0; k < NCH; k++) begin
                cmp_buf_q[k] <= '0;
                mode_q[k]    <= OMODE_OFF_A;
            end
        end else if (wr_en) begin
            if (wr_addr == A_TOP) top_buf_q <= wr_data;
            if (wr_addr == A_CTRL) begin
                sel_q <= wr_data[2:0];
                for (int k = 0; k < NCH; k++)
                    mode_q[k] <= omode_e'(wr_data[3 + 2*k +: 2]);
            end
            for (int k = 0; k < NCH; k++)
                if (wr_addr == ADDR_W'(k + 1)) cmp_buf_q[k] <= wr_data;
        end
    end

    assign set_vec = {evt.at_top, evt.at_bottom, hits};
    assign clr_vec = (wr_en && (wr_addr == A_FLAG)) ? wr_data[NF-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_vec) | set_vec;
    end
    assign flags_o = flags_q;

    pfc_pwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel_q),
        .tick (tick)
    );

    pfc_pwm_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .top_buf (top_buf_q),
        .cnt     (cnt_o),
        .top_act (top_act),
        .top_eff (top_eff),
        .evt     (evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pfc_pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cnt     (cnt_o),
            .top_eff (top_eff),
            .up      (evt.up),
            .cmp_buf (cmp_buf_q[g]),
            .mode    (mode_q[g]),
            .hit     (hits[g]),
            .pwm     (pwm_o[g])
        );
    end
endmodule

// File: rtl/pfc_pwm_checker.sv
module pfc_pwm_checker #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NCH    = 2,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  top_act,
    input logic [NCH+1:0]    flags,
    input logic [NCH-1:0]    pwm,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NCH+1:0]    wr_bits
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NCH + 1);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NCH + 2);

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt)); // R1
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= top_act); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != '0) |=> (cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1))); // R2
    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(wr_en && wr_addr == A_CTRL)) |=> $stable(pwm)); // R3
    AST_FLAG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ((flags & ~$past(flags)) == '0)); // R10
    AST_TOP_FLAG_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[NCH+1]) |-> ($past(cnt) == $past(top_act)) && ($past(cnt) != '0)); // R10
    AST_BOTTOM_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[NCH]) |-> ($past(cnt) == '0)); // R10
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_FLAG && !tick) |=> ((flags & $past(wr_bits)) == '0)); // R11
endmodule

bind pfc_pwm_timer pfc_pwm_checker #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (cnt_o),
    .top_act (top_act),
    .flags   (flags_o),
    .pwm     (pwm_o),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bits (wr_data[NCH+1:0])
);

// File: tb/test_pfc_pwm_timer.sv
module test_pfc_pwm_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  pwm_o;
    logic [3:0]  flags_o;
    logic [15:0] cnt_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pfc_pwm_timer i_pfc_pwm_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o),
        .flags_o (flags_o),
        .cnt_o   (cnt_o)
    );

    // top, cmp, mode0, mode1, expected high cycles ch0, ch1 (prescale 1)
    localparam logic [67:0] VECS [0:6] = '{
        {16'd10, 16'd3,  2'd2, 2'd3, 16'd6,  16'd14},
        {16'd10, 16'd0,  2'd2, 2'd3, 16'd0,  16'd20},
        {16'd10, 16'd10, 2'd2, 2'd3, 16'd20, 16'd0},
        {16'd20, 16'd7,  2'd2, 2'd3, 16'd14, 16'd26},
        {16'd10, 16'd5,  2'd0, 2'd1, 16'd0,  16'd0},
        {16'd1,  16'd1,  2'd2, 2'd3, 16'd2,  16'd0},
        {16'd16, 16'd8,  2'd3, 2'd2, 16'd16, 16'd16}
    };

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input logic [15:0] v);
        do @(negedge clk); while (cnt_o != v);
    endtask

    task automatic measure_period(output int p);
        do @(negedge clk); while (cnt_o == 0);
        do @(negedge clk); while (cnt_o != 0);
        p = 0;
        do begin @(negedge clk); p++; end while (cnt_o == 0);
        do begin @(negedge clk); p++; end while (cnt_o != 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int p;
        int mx;
        int h0;
        int h1;
        logic [15:0] held;
        logic [67:0] v;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12", "reset counter", cnt_o, 0);
        check("R12", "reset pwm", pwm_o, 0);
        check("R12", "reset flags", flags_o, 0);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            v = VECS[i];
            wr(3'd0, v[67:52]);
            wr(3'd1, v[51:36]);
            wr(3'd2, v[51:36]);
            wr(3'd3, {9'd0, v[33:32], v[35:34], 3'd1});
            repeat (200) @(negedge clk);
            h0 = 0; h1 = 0;
            repeat (2 * int'(v[67:52])) begin
                @(negedge clk);
                h0 += int'(pwm_o[0]);
                h1 += int'(pwm_o[1]);
            end
            check("R3/R4/R5/R6", $sformatf("vec%0d ch0 high cycles", i), h0, v[31:16]);
            check("R3/R4/R5/R6", $sformatf("vec%0d ch1 high cycles", i), h1, v[15:0]);
        end

        // prescaler and period: R1 R2
        wr(3'd0, 16'd5);  wr(3'd3, 16'd1); measure_period(p); check("R2", "period top5 div1", p, 10);
        wr(3'd0, 16'd4);  wr(3'd3, 16'd2); measure_period(p); check("R1", "period top4 div8", p, 64);
        wr(3'd0, 16'd2);  wr(3'd3, 16'd3); measure_period(p); check("R1", "period top2 div64", p, 256);
        wr(3'd0, 16'd1);  wr(3'd3, 16'd4); measure_period(p); check("R1", "period top1 div256", p, 512);
        wr(3'd0, 16'd1);  wr(3'd3, 16'd5); measure_period(p); check("R1", "period top1 div1024", p, 2048);
        wr(3'd0, 16'd5);  wr(3'd3, 16'd1);
        repeat (30) @(negedge clk);
        wait_cnt(3);
        wr(3'd3, 16'd0);
        held = cnt_o;
        repeat (40) @(negedge clk);
        check("R1", "sel 0 holds counter", cnt_o, held);
        wr(3'd3, 16'd7);
        held = cnt_o;
        repeat (40) @(negedge clk);
        check("R1", "sel 7 holds counter", cnt_o, held);

        // compare buffering: R7 R3
        wr(3'd0, 16'd100);
        wr(3'd1, 16'd50);
        wr(3'd3, 16'h0011);
        repeat (500) @(negedge clk);
        wait_cnt(0);
        wait_cnt(20);
        wr(3'd1, 16'd10);
        check("R3", "ch0 high below compare", pwm_o[0], 1);
        wait_cnt(55);
        check("R7", "old compare still active mid-period", pwm_o[0], 0);
        wait_cnt(0);
        wait_cnt(5);
        check("R7", "new compare: high below 10", pwm_o[0], 1);
        wait_cnt(15);
        check("R7", "new compare applied after zero", pwm_o[0], 0);

        // ceiling buffering: R8
        wait_cnt(0);
        wait_cnt(30);
        wr(3'd0, 16'd40);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 0);
        check("R8", "old ceiling kept this period", mx, 100);
        mx = 0;
        do begin @(negedge clk); if (int'(cnt_o) > mx) mx = int'(cnt_o); end while (cnt_o != 0);
        check("R8", "new ceiling next period", mx, 40);

        // flags: R9 R10 R11
        wr(3'd0, 16'd10);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd7);
        wr(3'd3, 16'h0051);
        repeat (200) @(negedge clk);
        wait_cnt(0);
        wait_cnt(5);
        wr(3'd4, 16'h000F);
        check("R11", "all flags cleared", flags_o, 0);
        wait_cnt(10);
        check("R10", "ceiling flag before enabled cycle", flags_o[3], 0);
        check("R9", "ch1 match flag after crossing 7", flags_o[1], 1);
        @(negedge clk);
        check("R10", "ceiling flag after enabled cycle", flags_o[3], 1);
        wait_cnt(3);
        check("R9", "ch0 match flag at compare cycle", flags_o[0], 0);
        @(negedge clk);
        check("R9", "ch0 match flag next cycle", flags_o[0], 1);
        wait_cnt(0);
        check("R10", "zero flag at zero cycle", flags_o[2], 0);
        @(negedge clk);
        check("R10", "zero flag next cycle", flags_o[2], 1);
        wait_cnt(5);
        wr(3'd4, 16'h0001);
        check("R11", "clear only bit0", flags_o, 4'b1110);
        wr(3'd4, 16'h0000);
        check("R11", "zero write leaves flags", flags_o, 4'b1110);
        wait_cnt(0);
        wait_cnt(5);
        wr(3'd4, 16'h0008);
        check("R11", "ceiling flag cleared", flags_o[3], 0);
        wait_cnt(9);
        wr(3'd4, 16'h0008);
        check("R11", "set wins over clear", flags_o[3], 1);

        done = 1'b1;
        finish_run();
    end
endmodule